// File: doc/BRIEF.md
# Drift Compensator with Remainder Carry

This block works out how far a scheduled wakeup has to move so that it cancels the learned drift of the local oscillator. On each request it takes three inputs: the drift estimate, the number of local ticks until the next active timeslot starts, and the nominal tick time of that start. It returns a signed correction in whole ticks and the corrected wake time. The interval may span many inactive timeslots.

All internal arithmetic uses a fine time unit of 1/1024 µs, whatever the tick length. One tick is `TICK_UNITS` fine units: 256 for a 4 MHz timer and 31250 for a 32 768 Hz timer. The part of each correction that is smaller than a tick cannot be applied. The block keeps that part and adds it to the next request, so rounding losses do not build up over many wakeups. The result is computed over many cycles by one shared sequential divider, with a start/done handshake.

Top module: `drift_comp`

## Requirements
- R1: While `rst_ni` is low and after it rises, `busy_o`, `done_o`, `corr_ticks_o` and `wake_o` are zero and the carried remainder is zero. A reset in the middle of a run of requests discards any remainder.
- R2: `start_i` is accepted only while `busy_o` is low. `busy_o` is high in the cycle after acceptance and stays high until the result is ready. `done_o` is a single-cycle pulse with `busy_o` low. A `start_i` seen while busy is ignored, and the result is the one for the accepted inputs.
- R3: `drift_i` is a two's-complement drift in units of 1/1024 ppm. `interval_i` is an unsigned tick count. The fine correction is `interval_i * TICK_UNITS * drift_i / 1_024_000_000` fine units, truncated toward zero.
- R4: The fine correction plus the carried remainder is divided by `TICK_UNITS` and rounded to the nearest tick. An exact half tick rounds away from zero, so equal negative and positive totals give corrections of opposite sign and equal size.
- R5: The new carried remainder is the total minus `corr_ticks_o * TICK_UNITS`. Its magnitude never exceeds `TICK_UNITS/2`, and it is added into the total of the next request.
- R6: A high `resync_i`, given while idle, sets the carried remainder to zero for the next request.
- R7: `wake_o` is `nominal_i + corr_ticks_o` modulo 2^`TIME_W`, with `nominal_i` taken when the request is accepted.
- R8: `corr_ticks_o` and `wake_o` change only in the cycle that `done_o` is high, and they hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a compensation step |
| resync_i | input | 1 | Clear the carried remainder |
| drift_i | input | DRIFT_W | Signed drift estimate, 1/1024 ppm |
| interval_i | input | INTERVAL_W | Ticks until next active slot start |
| nominal_i | input | TIME_W | Uncompensated wake time in ticks |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result valid pulse |
| corr_ticks_o | output | CORR_W | Signed correction in ticks |
| wake_o | output | TIME_W | Compensated wake time |

## Verification
The bench builds exact half-tick totals of both signs. A design that rounds with a bias toward positive, or that truncates, returns -0 instead of -1 there. It also runs chains of sub-tick corrections that only add up to a whole tick on a later request. A design that drops the remainder returns zero on every request of such a chain, and one that ignores resync or reset carries a stale tick forward. Random requests with extreme drift and interval values, plus wake times close to wrap-around, catch sign and magnitude mistakes in the wide product and a carry lost in the modular add. A start pulse sent mid-computation with different inputs exposes a design that restarts or latches new operands.

// File: rtl/dcmp_pkg.sv
`timescale 1ns/1ps
package dcmp_pkg;
  // fine units per tick per ppm-scale: 1024 (drift scale) * 1e6 (ppm)
  localparam longint unsigned PPM_SCALE = 64'd1_024_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV_SCALE,
    ST_MERGE,
    ST_DIV_TICK
  } state_e;
endpackage

// File: rtl/dcmp_mag_mul.sv
`timescale 1ns/1ps
module dcmp_mag_mul #(
  parameter int DRIFT_W    = 20,
  parameter int INTERVAL_W = 24,
  parameter int TICK_UNITS = 256,
  parameter int OUT_W      = 54
) (
  input  logic [DRIFT_W-1:0]    drift_i,
  input  logic [INTERVAL_W-1:0] interval_i,
  output logic                  neg_o,
  output logic [OUT_W-1:0]      mag_o
);
  logic [DRIFT_W-1:0] drift_mag;

  always_comb begin
    drift_mag = drift_i[DRIFT_W-1] ? DRIFT_W'(-drift_i) : drift_i;
    mag_o     = OUT_W'(interval_i) * OUT_W'(TICK_UNITS) * OUT_W'(drift_mag);
    neg_o     = drift_i[DRIFT_W-1];
  end
endmodule

// File: rtl/dcmp_divu.sv
`timescale 1ns/1ps
module dcmp_divu #(
  parameter int W = 54
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W);

  logic [W:0]       acc_q;
  logic [W-1:0]     quo_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       shifted, diff;
  logic             ge;

  always_comb begin
    shifted = {acc_q[W-1:0], quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    ge      = shifted >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CNT_W'(W - 1);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      acc_q <= ge ? diff : shifted;
      quo_q <= {quo_q[W-2:0], ge};
      if (cnt_q == '0) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = acc_q[W-1:0];
endmodule

// File: rtl/dcmp_round.sv
`timescale 1ns/1ps
module dcmp_round #(
  parameter int W          = 54,
  parameter int REM_W      = 10,
  parameter int TICK_UNITS = 256
) (
  input  logic                    neg_i,
  input  logic [W-1:0]            quot_i,
  input  logic [W-1:0]            rem_i,
  output logic signed [W-1:0]     ticks_o,
  output logic signed [REM_W-1:0] rem_o
);
  logic              up;
  logic [W-1:0]      mag;
  logic signed [W-1:0] res_mag;

  always_comb begin
    // ties go away from zero, mirrored for negative totals
    up      = {rem_i, 1'b0} >= (W + 1)'(TICK_UNITS);
    mag     = quot_i + W'(up);
    res_mag = up ? ($signed(rem_i) - W'(TICK_UNITS)) : $signed(rem_i);
    ticks_o = neg_i ? -$signed(mag) : $signed(mag);
    rem_o   = REM_W'(neg_i ? -res_mag : res_mag);
  end
endmodule

// File: rtl/drift_comp.sv
`timescale 1ns/1ps
module drift_comp #(
  parameter int DRIFT_W    = 20,
  parameter int INTERVAL_W = 24,
  parameter int TIME_W     = 32,
  parameter int CORR_W     = 32,
  parameter int TICK_UNITS = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     resync_i,
  input  logic [DRIFT_W-1:0]       drift_i,
  input  logic [INTERVAL_W-1:0]    interval_i,
  input  logic [TIME_W-1:0]        nominal_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [CORR_W-1:0] corr_ticks_o,
  output logic [TIME_W-1:0]        wake_o
);
  import dcmp_pkg::*;

  localparam int TICK_W = $clog2(TICK_UNITS + 1);
  localparam int REM_W  = TICK_W + 1;
  localparam int PROD_W = INTERVAL_W + TICK_W + DRIFT_W;
  localparam int DIV_W  = PROD_W + 1;

  state_e                  state_q;
  logic [DRIFT_W-1:0]      drift_q;
  logic [INTERVAL_W-1:0]   interval_q;
  logic [TIME_W-1:0]       nominal_q;
  logic                    neg_q;
  logic signed [DIV_W-1:0] total_q;
  logic signed [REM_W-1:0] rem_q;
  logic signed [CORR_W-1:0] corr_q;
  logic [TIME_W-1:0]       wake_q;
  logic                    done_q;

  logic                    mul_neg;
  logic [DIV_W-1:0]        mul_mag;
  logic                    div_start, div_done;
  logic [DIV_W-1:0]        div_dividend, div_divisor, div_quot, div_rem;
  logic [DIV_W-1:0]        total_abs;
  logic signed [DIV_W-1:0] q_signed, rnd_ticks;
  logic signed [REM_W-1:0] rnd_rem;
  logic                    finish;

  dcmp_mag_mul #(
    .DRIFT_W(DRIFT_W), .INTERVAL_W(INTERVAL_W),
    .TICK_UNITS(TICK_UNITS), .OUT_W(DIV_W)
  ) u_mul (
    .drift_i(drift_q), .interval_i(interval_q),
    .neg_o(mul_neg), .mag_o(mul_mag)
  );

  // one divider shared by the ppm scaling and the tick split
  always_comb begin
    total_abs    = total_q[DIV_W-1] ? DIV_W'(-total_q) : DIV_W'(total_q);
    div_start    = (state_q == ST_MUL) || (state_q == ST_MERGE);
    div_dividend = (state_q == ST_MUL) ? mul_mag : total_abs;
    div_divisor  = (state_q == ST_MUL) ? DIV_W'(PPM_SCALE) : DIV_W'(TICK_UNITS);
    q_signed     = $signed(div_quot);
    finish       = (state_q == ST_DIV_TICK) && div_done;
  end

  dcmp_divu #(.W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i(div_dividend), .divisor_i(div_divisor),
    .done_o(div_done), .quot_o(div_quot), .rem_o(div_rem)
  );

  dcmp_round #(.W(DIV_W), .REM_W(REM_W), .TICK_UNITS(TICK_UNITS)) u_rnd (
    .neg_i(total_q[DIV_W-1]), .quot_i(div_quot), .rem_i(div_rem),
    .ticks_o(rnd_ticks), .rem_o(rnd_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      drift_q    <= '0;
      interval_q <= '0;
      nominal_q  <= '0;
      neg_q      <= 1'b0;
      total_q    <= '0;
      corr_q     <= '0;
      wake_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          drift_q    <= drift_i;
          interval_q <= interval_i;
          nominal_q  <= nominal_i;
          state_q    <= ST_MUL;
        end
        ST_MUL: begin
          neg_q   <= mul_neg;
          state_q <= ST_DIV_SCALE;
        end
        ST_DIV_SCALE: if (div_done) begin
          total_q <= (neg_q ? -q_signed : q_signed) + DIV_W'(rem_q);
          state_q <= ST_MERGE;
        end
        ST_MERGE: state_q <= ST_DIV_TICK;
        ST_DIV_TICK: if (div_done) begin
          corr_q  <= CORR_W'(rnd_ticks);
          wake_q  <= nominal_q + TIME_W'(rnd_ticks);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (resync_i) rem_q <= '0;
    else if (finish)   rem_q <= rnd_rem;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign corr_ticks_o = corr_q;
  assign wake_o       = wake_q;
endmodule

// File: rtl/dcmp_check.sv
`timescale 1ns/1ps
module dcmp_check #(
  parameter int REM_W      = 10,
  parameter int CORR_W     = 32,
  parameter int TIME_W     = 32,
  parameter int TICK_UNITS = 256
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     resync_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic signed [CORR_W-1:0] corr_ticks_o,
  input logic [TIME_W-1:0]        wake_o,
  input logic signed [REM_W-1:0]  rem_q
);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_rem_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (2 * int'(rem_q) <= TICK_UNITS) && (2 * int'(rem_q) >= -TICK_UNITS));

  p_resync_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (rem_q == '0));

  p_hold_corr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(corr_ticks_o) && $stable(wake_o)));
endmodule

bind drift_comp dcmp_check #(
  .REM_W(REM_W), .CORR_W(CORR_W), .TIME_W(TIME_W), .TICK_UNITS(TICK_UNITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .resync_i(resync_i),
  .busy_o(busy_o), .done_o(done_o), .corr_ticks_o(corr_ticks_o),
  .wake_o(wake_o), .rem_q(rem_q)
);

// File: tb/drift_comp_test.sv
`timescale 1ns/1ps
module drift_comp_test;
  localparam int DW = 20, IW = 24, TW = 32, CW = 32, TU = 256;
  localparam longint SCALE = 64'd1024000000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, resync = 1'b0;
  logic [DW-1:0] drift = '0;
  logic [IW-1:0] interval = '0;
  logic [TW-1:0] nominal = '0;
  logic busy, done;
  logic signed [CW-1:0] corr;
  logic [TW-1:0] wake;

  int checks = 0, fails = 0;
  longint m_rem = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  drift_comp #(.DRIFT_W(DW), .INTERVAL_W(IW), .TIME_W(TW), .CORR_W(CW),
               .TICK_UNITS(TU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .resync_i(resync),
    .drift_i(drift), .interval_i(interval), .nominal_i(nominal),
    .busy_o(busy), .done_o(done), .corr_ticks_o(corr), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(input longint d, input longint iv);
    longint prod, cu, total, m, q, r, t;
    prod  = iv * TU * d;
    cu    = prod / SCALE;
    total = cu + m_rem;
    m     = (total < 0) ? -total : total;
    q     = m / TU;
    r     = m % TU;
    if (2 * r >= TU) q++;
    t     = (total < 0) ? -q : q;
    m_rem = total - t * TU;
    return t;
  endfunction

  task automatic run_op(input int d, input int unsigned iv, input logic [TW-1:0] nom,
                        input string req, input bit poke);
    longint t;
    logic [TW-1:0] ew;
    int n;
    @(negedge clk);
    drift = d[DW-1:0]; interval = iv[IW-1:0]; nominal = nom; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    if (poke) begin
      drift = ~drift; interval = ~interval; nominal = ~nominal; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      chk(1'b0, "R2 done timeout", 0, 1);
    end else begin
      t  = model_step(longint'(d), longint'(iv));
      ew = nom + TW'(t);
      chk(longint'(corr) == t, req, longint'(corr), t);
      chk(wake == ew, "R7 wake time", longint'(wake), longint'(ew));
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R2 done single pulse", longint'(done), 0);
      @(negedge clk);
      chk(longint'(corr) == t && wake == ew, "R8 outputs hold", longint'(corr), t);
    end
  endtask

  task automatic do_resync();
    @(negedge clk); resync = 1'b1;
    @(negedge clk); resync = 1'b0;
    m_rem = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 flags in reset", longint'(busy), 0);
    chk(corr == 0 && wake == 0, "R1 outputs in reset", longint'(corr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && corr == 0 && wake == 0, "R1 after reset", longint'(wake), 0);

    // R3 zero and simple cases
    run_op(0, 24'hFFFFFF, 32'd1000, "R3 zero drift", 0);
    run_op(40960, 0, 32'd77, "R3 zero interval", 0);

    // R4 exact half tick, both signs (12500*40960 -> 128 units)
    do_resync();
    run_op(40960, 12500, 32'd500, "R4 half tick positive", 0);
    do_resync();
    run_op(-40960, 12500, 32'd500, "R4 half tick negative", 0);

    // R5 sub-tick carry: 100 units per step
    do_resync();
    run_op(40000, 10000, 32'd10, "R5 carry step one", 0);
    run_op(40000, 10000, 32'd20, "R5 carry step two", 0);
    run_op(-40000, 10000, 32'd30, "R5 carry negative", 0);

    // R6 resync drops the carry
    do_resync();
    run_op(40000, 10000, 32'd10, "R6 before resync", 0);
    do_resync();
    run_op(40000, 10000, 32'd10, "R6 after resync", 0);

    // R1 reset drops the carry
    run_op(40000, 10000, 32'd10, "R1 build carry", 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_rem = 0;
    run_op(40000, 10000, 32'd10, "R1 carry cleared by reset", 0);

    // R2 start while busy is ignored
    run_op(81920, 4000000, 32'd123456, "R2 start while busy", 1);

    // R7 wrap and extremes
    run_op(524287, 24'hFFFFFF, 32'hFFFF_FFF0, "R7 wrap positive", 0);
    run_op(-524288, 24'hFFFFFF, 32'h0000_0005, "R7 wrap negative", 0);

    // R3 R4 R5 random
    for (int i = 0; i < 200; i++) begin
      int d;
      int unsigned iv;
      if ((i % 40) == 0) do_resync();
      d  = int'($urandom_range(0, 163840)) - 81920;
      iv = $urandom_range(0, 24'hFFFFFF);
      run_op(d, iv, $urandom, "R3 random step", (i % 17) == 3);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule